// File: doc/BRIEF.md
# Clock Source Controller with Main-Oscillator Failover

This block chooses and sequences the CPU clock source of a small microcontroller. One configuration word holds the on/off control of the low-speed on-chip oscillator, the PLL enable, the PLL input-divider and multiplier codes, the requested CPU source, the low-speed divide mode and the oscillator-stop detection settings. The block drives the oscillator and PLL enables and the divider and multiplier codes. It also drives a two-bit select that tells the downstream glitch-free mux which source is in use.

A source change takes effect only when the new clock can be used. The low-speed oscillator must first pass a settling count. The PLL must be enabled and must have passed a lock count. The low-speed clock arrives as a one-cycle `lso_tick` per oscillator period. While that clock is the CPU source, an internal divider turns these ticks into `cpu_ls_tick` pulses.

When detection is armed and the main oscillator stops, the block moves to the low-speed oscillator by itself. It turns that oscillator on, requests it as the source, sets a sticky flag and raises a one-cycle interrupt. Configuration writes are plain one-cycle strobes and are always taken: there is no stream traffic and no back-pressure.

Top module: `clksrc_ctrl`

## Requirements
- R1: After reset the PLL enable is 0, the input-divider code is 00, the multiplier code is 010, the low-speed oscillator is on, `clk_sel` is 10 (low-speed) with divide-by-8 active, and the flag and interrupt are 0.
- R2: The input-divider code sits in `cfg_wdata[3:2]`, where 00 means /1, 01 means /2 and 10 means /4. A write of code 11 leaves the held code unchanged.
- R3: The multiplier code sits in `cfg_wdata[6:4]`, where 001 means x2, 010 means x4, 011 means x6 and 100 means x8. A write of 000 or of 101 to 111 leaves the held code unchanged.
- R4: `cfg_wdata[0]` controls the low-speed oscillator and is active-low: 0 turns it on and 1 turns it off, so `lso_en` is the inverse of the held bit. While the low-speed source is requested or in use, the held bit is forced to 0 and a write of 1 has no effect.
- R5: `lso_ready` rises SETTLE_CYC clock edges after `lso_en` rises. It is 0 whenever `lso_en` is 0.
- R6: The requested source sits in `cfg_wdata[8:7]`, where 00 means main, 01 means PLL and 10 means low-speed; code 11 is ignored. `clk_sel` follows a request on the next edge. For the low-speed source it waits until `lso_ready` is 1.
- R7: `pll_locked` rises LOCK_CYC edges after the PLL enable (`cfg_wdata[1]`) is set. A write that selects the PLL while `pll_locked` is 0 leaves the requested source unchanged.
- R8: A write that clears the PLL enable has no effect while the PLL is requested or in use.
- R9: Failover needs both `cfg_wdata[10]` (detection enable) and `cfg_wdata[11]` (interrupt mode) to be 1. Under that condition, a rising edge on `main_osc_stop` turns the low-speed oscillator on and requests it as the source. Otherwise the rising edge changes nothing.
- R10: A failover sets `fail_flag` and pulses `fail_irq` for exactly one cycle. A write with `cfg_wdata[12]` = 1 clears the flag. When a clear and a failover land on the same edge, the flag ends up set.
- R11: While `clk_sel` is 10, `cpu_ls_tick` pulses once per 8 `lso_tick` pulses if `cfg_wdata[9]` = 1, and once per tick if it is 0. It stays 0 while another source is in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 13 | Configuration word (field positions in R2 to R11) |
| main_osc_stop | input | 1 | Main oscillator stopped indication (level) |
| lso_tick | input | 1 | One pulse per low-speed oscillator period |
| lso_en | output | 1 | Low-speed oscillator enable |
| pll_en | output | 1 | PLL enable |
| pll_div | output | 2 | PLL input-divider code |
| pll_mul | output | 3 | PLL multiplier code |
| clk_sel | output | 2 | Active CPU source: 00 main, 01 PLL, 10 low-speed |
| lso_ready | output | 1 | Low-speed oscillator settled |
| pll_locked | output | 1 | PLL lock wait finished |
| cpu_ls_tick | output | 1 | Low-speed CPU clock enable pulse |
| fail_flag | output | 1 | Sticky failover flag |
| fail_irq | output | 1 | One-cycle failover interrupt |

## Verification
The bench samples `lso_ready` on the edge just before and the edge just after the end of the settling count. It checks `pll_locked` the same way around the end of the lock count, which catches a timer that is off by one in either direction. It tries a PLL select before lock and a PLL disable while the PLL is in use. A controller that accepted either of these would hand the CPU a clock that is not running. It writes illegal divider and multiplier codes, including the just-out-of-range multiplier code 101, which a loose range check would let into the PLL codes. It raises the stop input with detection only partly armed and then fully armed, times the return to the low-speed source against the settling count, and lands a flag clear on the same edge as a failover, where a clear-priority design would lose the event.

// File: rtl/clksrc_pkg.sv
`timescale 1ns/1ps
package clksrc_pkg;

  typedef enum logic [1:0] {
    SRC_MAIN = 2'b00,
    SRC_PLL  = 2'b01,
    SRC_LSO  = 2'b10
  } src_e;

  localparam int unsigned CFG_W = 13;

  // configuration word bit positions
  localparam int unsigned B_LSO_OFF = 0;
  localparam int unsigned B_PLL_EN  = 1;
  localparam int unsigned B_DIV_LO  = 2;
  localparam int unsigned B_MUL_LO  = 4;
  localparam int unsigned B_SRC_LO  = 7;
  localparam int unsigned B_DIV8    = 9;
  localparam int unsigned B_DET_EN  = 10;
  localparam int unsigned B_IRQ_MD  = 11;
  localparam int unsigned B_CLR     = 12;

  typedef struct packed {
    logic       lso_off;
    logic       pll_en;
    logic [1:0] div;
    logic [2:0] mul;
    src_e       src;
    logic       ls_div8;
    logic       det_en;
    logic       irq_mode;
  } cfg_t;

  function automatic logic div_code_ok(input logic [1:0] c);
    return c != 2'b11;
  endfunction

  function automatic logic mul_code_ok(input logic [2:0] c);
    return (c != 3'b000) && (c <= 3'b100);
  endfunction

  function automatic logic src_code_ok(input logic [1:0] c);
    return c != 2'b11;
  endfunction

endpackage

// File: rtl/clksrc_settle.sv
`timescale 1ns/1ps
module clksrc_settle #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic done
);
  generate
    if (CYCLES == 0) begin : g_none
      assign done = en;
    end else begin : g_count
      localparam int unsigned CW = $clog2(CYCLES + 1);
      localparam logic [CW-1:0] LIMIT = CW'(CYCLES);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (!en)         cnt <= '0;
        else if (cnt != LIMIT) cnt <= cnt + CW'(1);
      end

      assign done = en && (cnt == LIMIT);
    end
  endgenerate
endmodule

// File: rtl/clksrc_lsdiv.sv
`timescale 1ns/1ps
module clksrc_lsdiv #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  input  logic active,
  input  logic div_on,
  output logic tick_out
);
  generate
    if (DIV <= 1) begin : g_pass
      always_ff @(posedge clk) begin
        if (!rst_n) tick_out <= 1'b0;
        else        tick_out <= active & tick_in & (div_on | ~div_on);
      end
    end else begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] phase;
      logic          wrap;

      assign wrap = (phase == LAST);

      always_ff @(posedge clk) begin
        if (!rst_n)       phase <= '0;
        else if (tick_in) phase <= wrap ? '0 : phase + PW'(1);
      end

      always_ff @(posedge clk) begin
        if (!rst_n) tick_out <= 1'b0;
        else        tick_out <= active & tick_in & (div_on ? wrap : 1'b1);
      end
    end
  endgenerate
endmodule

// File: rtl/clksrc_cfg.sv
`timescale 1ns/1ps
module clksrc_cfg
  import clksrc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             fail_evt,
  input  src_e             eff_src,
  input  logic             pll_locked,
  output cfg_t             cfg,
  output logic             fail_flag
);
  cfg_t nxt;
  logic flag_nxt;
  logic [1:0] wr_div;
  logic [2:0] wr_mul;
  logic [1:0] wr_src;

  assign wr_div = wr_data[B_DIV_LO +: 2];
  assign wr_mul = wr_data[B_MUL_LO +: 3];
  assign wr_src = wr_data[B_SRC_LO +: 2];

  always_comb begin
    nxt = cfg;
    if (wr_en) begin
      nxt.lso_off  = wr_data[B_LSO_OFF];
      nxt.ls_div8  = wr_data[B_DIV8];
      nxt.det_en   = wr_data[B_DET_EN];
      nxt.irq_mode = wr_data[B_IRQ_MD];
      if (div_code_ok(wr_div)) nxt.div = wr_div;
      if (mul_code_ok(wr_mul)) nxt.mul = wr_mul;
      // a PLL request is dropped unless the lock wait has completed
      if (src_code_ok(wr_src) && (src_e'(wr_src) != SRC_PLL || pll_locked))
        nxt.src = src_e'(wr_src);
      // PLL may not be switched off under a running or pending PLL source
      if (wr_data[B_PLL_EN] || !(nxt.src == SRC_PLL || eff_src == SRC_PLL))
        nxt.pll_en = wr_data[B_PLL_EN];
    end
    if (fail_evt) nxt.src = SRC_LSO;
    if (nxt.src == SRC_LSO || eff_src == SRC_LSO) nxt.lso_off = 1'b0;
  end

  always_comb begin
    flag_nxt = fail_flag;
    if (wr_en && wr_data[B_CLR]) flag_nxt = 1'b0;
    if (fail_evt)                flag_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg.lso_off  <= 1'b0;
      cfg.pll_en   <= 1'b0;
      cfg.div      <= 2'b00;
      cfg.mul      <= 3'b010;
      cfg.src      <= SRC_LSO;
      cfg.ls_div8  <= 1'b1;
      cfg.det_en   <= 1'b0;
      cfg.irq_mode <= 1'b0;
      fail_flag    <= 1'b0;
    end else begin
      cfg       <= nxt;
      fail_flag <= flag_nxt;
    end
  end
endmodule

// File: rtl/clksrc_ctrl.sv
`timescale 1ns/1ps
module clksrc_ctrl
  import clksrc_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 16,
  parameter int unsigned LOCK_CYC   = 24,
  parameter int unsigned LS_DIV     = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [12:0] cfg_wdata,
  input  logic        main_osc_stop,
  input  logic        lso_tick,
  output logic        lso_en,
  output logic        pll_en,
  output logic [1:0]  pll_div,
  output logic [2:0]  pll_mul,
  output logic [1:0]  clk_sel,
  output logic        lso_ready,
  output logic        pll_locked,
  output logic        cpu_ls_tick,
  output logic        fail_flag,
  output logic        fail_irq
);
  cfg_t cfg;
  src_e eff_src;
  logic stop_q;
  logic fail_evt;

  // failover fires on the rising edge of the stop indication when fully armed
  assign fail_evt = cfg.det_en & cfg.irq_mode & main_osc_stop & ~stop_q;

  clksrc_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_we),
    .wr_data    (cfg_wdata),
    .fail_evt   (fail_evt),
    .eff_src    (eff_src),
    .pll_locked (pll_locked),
    .cfg        (cfg),
    .fail_flag  (fail_flag)
  );

  clksrc_settle #(.CYCLES(SETTLE_CYC)) u_lso_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (lso_en),
    .done  (lso_ready)
  );

  clksrc_settle #(.CYCLES(LOCK_CYC)) u_pll_lock (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (pll_en),
    .done  (pll_locked)
  );

  clksrc_lsdiv #(.DIV(LS_DIV)) u_lsdiv (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_in  (lso_tick),
    .active   (eff_src == SRC_LSO),
    .div_on   (cfg.ls_div8),
    .tick_out (cpu_ls_tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_q   <= 1'b0;
      fail_irq <= 1'b0;
    end else begin
      stop_q   <= main_osc_stop;
      fail_irq <= fail_evt;
    end
  end

  // the active source follows the request once the target clock is usable
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eff_src <= SRC_LSO;
    end else if (cfg.src != eff_src) begin
      case (cfg.src)
        SRC_LSO:  if (lso_ready)  eff_src <= SRC_LSO;
        SRC_PLL:  if (pll_locked) eff_src <= SRC_PLL;
        SRC_MAIN: eff_src <= SRC_MAIN;
        default:  eff_src <= eff_src;
      endcase
    end
  end

  assign lso_en  = ~cfg.lso_off;
  assign pll_en  = cfg.pll_en;
  assign pll_div = cfg.div;
  assign pll_mul = cfg.mul;
  assign clk_sel = eff_src;
endmodule

// File: rtl/clksrc_ctrl_chk.sv
`timescale 1ns/1ps
module clksrc_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lso_en,
  input logic       pll_en,
  input logic [1:0] pll_div,
  input logic [2:0] pll_mul,
  input logic [1:0] clk_sel,
  input logic       lso_ready,
  input logic       pll_locked,
  input logic       fail_flag,
  input logic       fail_irq
);
  p_div_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pll_div != 2'b11);

  p_mul_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_mul != 3'b000) && (pll_mul <= 3'b100));

  p_lso_kept_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'b10) |-> lso_en);

  p_ready_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lso_ready |-> lso_en);

  p_ls_entry_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'b10 && $past(clk_sel) != 2'b10) |-> $past(lso_ready));

  p_pll_use_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'b01) |-> pll_locked);

  p_locked_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pll_locked |-> pll_en);

  p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fail_irq |=> !fail_irq);

  p_irq_with_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fail_irq |-> fail_flag);
endmodule

bind clksrc_ctrl clksrc_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lso_en     (lso_en),
  .pll_en     (pll_en),
  .pll_div    (pll_div),
  .pll_mul    (pll_mul),
  .clk_sel    (clk_sel),
  .lso_ready  (lso_ready),
  .pll_locked (pll_locked),
  .fail_flag  (fail_flag),
  .fail_irq   (fail_irq)
);

// File: tb/clksrc_ctrl_bench.sv
`timescale 1ns/1ps
module clksrc_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [12:0] cfg_wdata = '0;
  logic        main_osc_stop = 1'b0;
  logic        lso_tick = 1'b0;
  logic        lso_en, pll_en, lso_ready, pll_locked, cpu_ls_tick, fail_flag, fail_irq;
  logic [1:0]  pll_div, clk_sel;
  logic [2:0]  pll_mul;

  clksrc_ctrl u_clksrc_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .main_osc_stop(main_osc_stop), .lso_tick(lso_tick),
    .lso_en(lso_en), .pll_en(pll_en), .pll_div(pll_div), .pll_mul(pll_mul),
    .clk_sel(clk_sel), .lso_ready(lso_ready), .pll_locked(pll_locked),
    .cpu_ls_tick(cpu_ls_tick), .fail_flag(fail_flag), .fail_irq(fail_irq)
  );

  always #10 clk = ~clk;

  localparam int F_LSOEN = 0, F_PLLEN = 1, F_DIV = 2, F_MUL = 3, F_SEL = 4,
                 F_RDY = 5, F_LOCK = 6, F_FLAG = 7, F_IRQ = 8;

  typedef struct { int fld; int val; string tag; } exp_t;
  exp_t sb_q[$];
  int checks = 0, fails = 0, tick_cnt = 0;
  bit done = 0;

  logic       s_off = 0, s_pll = 0, s_d8 = 1, s_det = 0, s_irq = 0;
  logic [1:0] s_div = 0, s_src = 2'b10;
  logic [2:0] s_mul = 3'b010;

  function automatic int observe(int f);
    case (f)
      F_LSOEN: return int'(lso_en);
      F_PLLEN: return int'(pll_en);
      F_DIV:   return int'(pll_div);
      F_MUL:   return int'(pll_mul);
      F_SEL:   return int'(clk_sel);
      F_RDY:   return int'(lso_ready);
      F_LOCK:  return int'(pll_locked);
      F_FLAG:  return int'(fail_flag);
      default: return int'(fail_irq);
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_f(int f, int v, string tag);
    exp_t e;
    e.fld = f; e.val = v; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compares queued expectations right after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, observe(e.fld), e.val);
      end
    end
  end

  always @(negedge clk) if (cpu_ls_tick) tick_cnt++;

  task automatic step();
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) step();
  endtask

  task automatic wr(logic clr);
    cfg_wdata = {clr, s_irq, s_det, s_d8, s_src, s_mul, s_div, s_pll, s_off};
    cfg_we = 1'b1;
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      lso_tick = 1'b1; step();
      lso_tick = 1'b0; step();
    end
    idle(2);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state (after first edge)
    expect_f(F_LSOEN, 1, "R1 lso_en");
    expect_f(F_PLLEN, 0, "R1 pll_en");
    expect_f(F_DIV,   0, "R1 pll_div");
    expect_f(F_MUL,   2, "R1 pll_mul");
    expect_f(F_SEL,   2, "R1 clk_sel");
    expect_f(F_RDY,   0, "R1 lso_ready");
    expect_f(F_LOCK,  0, "R1 pll_locked");
    expect_f(F_FLAG,  0, "R1 fail_flag");
    expect_f(F_IRQ,   0, "R1 fail_irq");
    step();
    // R5 settle boundary
    idle(13);
    expect_f(F_RDY, 0, "R5 ready one edge early");
    step();
    expect_f(F_RDY, 1, "R5 ready at settle count");
    step();

    // R11 divide-by-8 and undivided
    tick_cnt = 0;
    ticks(16);
    check("R11 div8 pulses", tick_cnt, 2);
    s_d8 = 0; wr(0); step();
    tick_cnt = 0;
    ticks(8);
    check("R11 undivided pulses", tick_cnt, 8);

    // R2 / R3 reserved codes rejected
    s_div = 2'b11; wr(0); expect_f(F_DIV, 0, "R2 code 11 rejected"); step();
    s_div = 2'b00; s_mul = 3'b000; wr(0); expect_f(F_MUL, 2, "R3 code 000 rejected"); step();
    s_mul = 3'b101; wr(0); expect_f(F_MUL, 2, "R3 code 101 rejected"); step();
    s_mul = 3'b111; wr(0); expect_f(F_MUL, 2, "R3 code 111 rejected"); step();
    s_div = 2'b01; s_mul = 3'b100; wr(0);
    expect_f(F_DIV, 1, "R2 div /2 accepted"); expect_f(F_MUL, 4, "R3 mul x8 accepted"); step();
    s_div = 2'b10; s_mul = 3'b001; wr(0);
    expect_f(F_DIV, 2, "R2 div /4 accepted"); expect_f(F_MUL, 1, "R3 mul x2 accepted"); step();

    // R4 off-write overridden while low-speed source in use
    s_off = 1; wr(0);
    expect_f(F_LSOEN, 1, "R4 forced on"); expect_f(F_RDY, 1, "R5 ready kept"); step();

    // R6 switch to main, R4 release
    s_src = 2'b00; wr(0);
    expect_f(F_SEL, 2, "R6 select lags request"); expect_f(F_LSOEN, 1, "R4 still forced"); step();
    expect_f(F_SEL, 0, "R6 main next edge"); step();
    wr(0);
    expect_f(F_LSOEN, 0, "R4 off accepted"); expect_f(F_RDY, 0, "R5 ready drops"); step();
    tick_cnt = 0;
    ticks(8);
    check("R11 no pulses off low-speed", tick_cnt, 0);

    // R7 PLL select without enable / before lock
    s_src = 2'b01; wr(0); step();
    expect_f(F_SEL, 0, "R7 PLL select ignored, no enable"); step();
    s_src = 2'b00; s_pll = 1; wr(0); expect_f(F_PLLEN, 1, "R7 pll_en set"); step();
    s_src = 2'b01; wr(0); expect_f(F_LOCK, 0, "R7 not locked"); step();
    expect_f(F_SEL, 0, "R7 PLL select ignored before lock"); step();
    idle(20);
    expect_f(F_LOCK, 0, "R7 lock one edge early"); step();
    expect_f(F_LOCK, 1, "R7 lock at count"); step();
    wr(0); expect_f(F_SEL, 0, "R6 PLL select lags"); step();
    expect_f(F_SEL, 1, "R7 PLL in use"); step();

    // R8 PLL disable rejected while in use
    s_pll = 0; wr(0); expect_f(F_PLLEN, 1, "R8 disable rejected"); step();
    s_pll = 1;

    // R9 partly armed: no action
    main_osc_stop = 1;
    expect_f(F_FLAG, 0, "R9 disarmed flag"); expect_f(F_IRQ, 0, "R9 disarmed irq"); step();
    expect_f(F_SEL, 1, "R9 disarmed source kept"); step();
    main_osc_stop = 0; step();
    s_det = 1; wr(0); step();
    main_osc_stop = 1;
    expect_f(F_FLAG, 0, "R9 half armed flag"); expect_f(F_LSOEN, 0, "R9 half armed lso"); step();
    main_osc_stop = 0; step();
    s_irq = 1; wr(0); step();

    // R9 / R10 failover
    main_osc_stop = 1;
    expect_f(F_IRQ, 1, "R10 irq pulse"); expect_f(F_FLAG, 1, "R10 flag set");
    expect_f(F_LSOEN, 1, "R9 lso started"); expect_f(F_SEL, 1, "R6 waits for settle");
    step();
    expect_f(F_IRQ, 0, "R10 irq one cycle"); expect_f(F_FLAG, 1, "R10 flag sticky"); step();
    idle(13);
    expect_f(F_RDY, 0, "R5 settle early"); step();
    expect_f(F_RDY, 1, "R5 settled"); expect_f(F_SEL, 1, "R6 not yet low-speed"); step();
    expect_f(F_SEL, 2, "R9 failover source active"); step();
    s_src = 2'b10;

    // R10 clear behaviour
    wr(0); expect_f(F_FLAG, 1, "R10 write 0 keeps flag"); step();
    wr(1); expect_f(F_FLAG, 0, "R10 write 1 clears"); step();
    main_osc_stop = 0; idle(2);
    main_osc_stop = 1; wr(1);
    expect_f(F_FLAG, 1, "R10 set wins over clear"); expect_f(F_IRQ, 1, "R10 irq on collision"); step();
    wr(1); expect_f(F_FLAG, 0, "R10 clear after collision"); step();

    idle(3);
    done = 1;
    report();
    $finish;
  end
endmodule